// File: doc/BRIEF.md
# Sliding-Window Speculative Carry Adder

This block adds two unsigned operands of equal width and returns a result of the same width. It speculates on carries: each result bit comes from its own small exact adder, and that adder sees only the current bit position and a fixed number of positions below it. A carry that starts further down is lost. The longest carry path is therefore only a few positions long, whatever the operand width. The price is an occasional wrong result, and that error can be large because it lands on a high-order bit.

The window depth is a parameter. When the window reaches bit 0 for every position, the block is an ordinary exact adder. A parameter can add a register on the result for timing closure. With that register the result appears one clock after the operands and clears under the active-low asynchronous reset. Without it the path from operands to result is purely combinational. The parameters are checked when the design is elaborated: the depth must be at least 1 and less than the width.

Top module: `win_spec_adder`

## Requirements
- R1: With window depth P, result bit i equals the top bit of the exact sum of operand slices [i:lo] with lo = max(0, i-P). Any carry from below lo is ignored. For width 8 and depth 2: 0x0F+0x01 gives 0x08, 0xFF+0x01 gives 0xF8, 0xFF+0xFF gives 0xFE, and 0xAA+0x55 gives 0xFF.
- R2: Result bits [P:0] always equal the same bits of the exact sum.
- R3: With depth equal to width-1, the result equals (a+b) mod 2^width for all operands.
- R4: There is no carry-out. The exact result wraps modulo 2^width, so with width 8, 0xFF+0x01 gives 0x00 in the exact configuration.
- R5: With the output register enabled, the result reflects the operands present at the previous rising clock edge. It holds between edges and is forced to zero while rst_ni is low, independent of the clock.
- R6: With the output register disabled, the result follows the operands without any clock edge.
- R7: For width 8 and depth 2, random operands give a nonzero number of results that differ from the exact sum. For depth 7 that number is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH | Speculative sum, same width as the operands |

## Verification
A speculation error and the modulo wrap can both hit the same pair of operands. With 0xFF+0x01, the carry is lost above the window in the depth-2 adder, and the carry-out is dropped in the exact adder. The bench drives that pair, and 0xFF+0xFF, to both configurations in the same cycle. It judges each result against its own bench model: 0xF8 for depth 2 and 0x00 for the exact configuration. Random operands then confirm that errors appear only above bit P and only in the speculative configuration.

// File: rtl/win_add_pkg.sv
package win_add_pkg;
  // lowest operand bit seen by the window that ends at pos
  function automatic int win_lo(input int pos, input int depth);
    return (pos > depth) ? pos - depth : 0;
  endfunction
endpackage

// File: rtl/win_slice.sv
module win_slice #(
  parameter int W = 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         s_o
);
  logic [W-1:0] c;

  assign c[0] = 1'b0;
  for (genvar k = 0; k < W-1; k++) begin : g_c
    assign c[k+1] = (a_i[k] & b_i[k]) | ((a_i[k] ^ b_i[k]) & c[k]);
  end

  assign s_o = a_i[W-1] ^ b_i[W-1] ^ c[W-1];
endmodule

// File: rtl/win_out_stage.sv
module win_out_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/win_spec_adder.sv
module win_spec_adder
  import win_add_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  if (DEPTH < 1 || DEPTH >= WIDTH) begin : g_bad_param
    $error("win_spec_adder: DEPTH must satisfy 1 <= DEPTH < WIDTH");
  end

  logic [WIDTH-1:0] sum_raw;

  // R1: one independent exact sub-adder per result bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int LO = win_lo(i, DEPTH);
    localparam int WW = i - LO + 1;
    win_slice #(.W(WW)) u_slice (
      .a_i (a_i[i:LO]),
      .b_i (b_i[i:LO]),
      .s_o (sum_raw[i])
    );
  end

  win_out_stage #(.W(WIDTH), .EN(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sum_raw),
    .q_o    (sum_o)
  );
endmodule

// File: rtl/win_spec_adder_chk.sv
module win_spec_adder_chk #(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] ref_sum;
  logic             no_gen;

  assign ref_sum = a_i + b_i;
  assign no_gen  = ((a_i & b_i) == '0);

  if (REG_OUT) begin : g_seq
    AST_LOW_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> sum_o[DEPTH:0] == $past(ref_sum[DEPTH:0]))
      else $error("low bits differ from exact sum"); // R2
    AST_NOGEN_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_gen |=> sum_o == $past(ref_sum))
      else $error("carry-free operands gave wrong sum"); // R1
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        AST_RESET_ZERO: assert (sum_o == '0)
          else $error("output not cleared in reset"); // R5
      end
    end
    if (DEPTH == WIDTH-1) begin : g_full
      AST_FULL_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> sum_o == $past(ref_sum))
        else $error("full-depth adder not exact"); // R3
    end
  end else begin : g_comb
    AST_LOW_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o[DEPTH:0] == ref_sum[DEPTH:0])
      else $error("low bits differ from exact sum"); // R2
    AST_NOGEN_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_gen |-> sum_o == ref_sum)
      else $error("carry-free operands gave wrong sum"); // R1
    if (DEPTH == WIDTH-1) begin : g_full
      AST_FULL_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_o == ref_sum)
        else $error("full-depth adder not exact"); // R3
    end
  end
endmodule

bind win_spec_adder win_spec_adder_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .sum_o(sum_o)
);

// File: tb/win_spec_adder_test.sv
module win_spec_adder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] a_r, b_r;
  logic [7:0] sum_win, sum_full;
  int total = 0;
  int bad   = 0;
  int miss_win  = 0;
  int miss_full = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  win_spec_adder #(.WIDTH(8), .DEPTH(2), .REG_OUT(1'b1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_r), .b_i(b_r), .sum_o(sum_win)
  );

  win_spec_adder #(.WIDTH(8), .DEPTH(7), .REG_OUT(1'b0)) uut_full (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_r), .b_i(b_r), .sum_o(sum_full)
  );

  function automatic logic [7:0] model_win(input logic [7:0] a, input logic [7:0] b, input int p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int lo = (i > p) ? i - p : 0;
      int w  = i - lo + 1;
      int sa = (int'(a) >> lo) & ((1 << w) - 1);
      int sb = (int'(b) >> lo) & ((1 << w) - 1);
      r[i] = 1'(((sa + sb) >> (w - 1)) & 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] model_exact(input logic [7:0] a, input logic [7:0] b);
    return 8'((int'(a) + int'(b)) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk_i);
    a_r = a;
    b_r = b;
    @(posedge clk_i);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    void'($urandom(32'd4711));
    rst_ni = 1'b1;
    a_r = 8'h5A;
    b_r = 8'h3C;
    #1 rst_ni = 1'b0;
    @(posedge clk_i); #5;
    chk("R5 reset clears output", sum_win, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 directed windows, R4 wrap in the same cycle
    apply(8'h0F, 8'h01);
    chk("R1 0x0F+0x01 window", sum_win, 8'h08);
    chk("R3 0x0F+0x01 exact", sum_full, 8'h10);
    apply(8'hFF, 8'h01);
    chk("R1 0xFF+0x01 window", sum_win, 8'hF8);
    chk("R4 0xFF+0x01 wraps", sum_full, 8'h00);
    apply(8'hFF, 8'hFF);
    chk("R1 0xFF+0xFF window", sum_win, 8'hFE);
    chk("R4 0xFF+0xFF wraps", sum_full, 8'hFE);
    apply(8'hAA, 8'h55);
    chk("R1 0xAA+0x55 carry-free", sum_win, 8'hFF);
    chk("R3 0xAA+0x55 exact", sum_full, 8'hFF);

    // R5 hold between edges, R6 combinational path
    apply(8'h12, 8'h34);
    @(negedge clk_i);
    a_r = 8'h01;
    b_r = 8'h01;
    #5;
    chk("R5 holds before edge", sum_win, model_win(8'h12, 8'h34, 2));
    chk("R6 follows operands without edge", sum_full, 8'h02);
    @(posedge clk_i); #5;
    chk("R5 updates after edge", sum_win, 8'h02);

    // R5 asynchronous reset mid-run
    apply(8'h77, 8'h11);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk("R5 async clear", sum_win, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int n = 0; n < 3000; n++) begin
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (n % 16 == 0) ra = 8'hFF;
      apply(ra, rb);
      chk("R1 random window", sum_win, model_win(ra, rb, 2));
      chk("R2 random low bits", {5'b0, sum_win[2:0]}, {5'b0, model_exact(ra, rb)[2:0]});
      chk("R3 random exact", sum_full, model_exact(ra, rb));
      if (sum_win !== model_exact(ra, rb)) miss_win++;
      if (sum_full !== model_exact(ra, rb)) miss_full++;
    end
    total++;
    if (miss_win == 0) begin
      bad++;
      $display("FAIL R7 depth-2 mismatches: actual=%0d expected=nonzero", miss_win);
    end
    chk("R7 depth-7 mismatches", 8'(miss_full), 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule